// File: doc/BRIEF.md
# Retriggerable Output Timer with Lockout

This block turns qualified motion pulses into an on/off output that stays on for a tick-counted duration. The duration is picked by a 4-bit code from sixteen values. The first four are quarter-minute steps. The other twelve are minute counts with uneven spacing. The code is sampled at every trigger that starts the timer or reloads it, so a trigger that arrives while the output is on restarts the full duration from the code present at that moment.

When the duration runs out, the block enters a lockout interval. The 2-bit lockout select gives the length of that interval, and every trigger during it is ignored. A level inhibit input stops a trigger from switching the output on when it is off. Once the output is on, the inhibit input has no effect.

A separate indicator output is a retriggerable one-shot that fires on every trigger in every state, whatever the inhibit level. All time is counted in `tick` cycles, so a slower tick stretches every interval in proportion.

Top module: `otl_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_on` and `ind_on` are low and the timer is idle.
- R2: In the idle state, a cycle with `trig` high and `inhibit` low raises `out_on` at the next clock edge. For `tsel` codes 0, 1, 2 and 3, `out_on` stays high for 900, 1800, 2700 and 3600 tick cycles.
- R3: For `tsel` codes 4 to 15, the on time is 3600 ticks multiplied by a minute count. Codes 4 to 12 give 2 to 10 minutes (code minus 2). Code 13 gives 12, code 14 gives 14 and code 15 gives 15 minutes. The largest value, 54000 ticks, fits the counter.
- R4: A trigger while `out_on` is high keeps the output high. It reloads the full duration of the `tsel` code sampled with that trigger.
- R5: When the on time expires, `out_on` falls and a lockout starts. `lsel` is decoded as 2'b00 = 60, 2'b01 = 240, 2'b10 = 480 and 2'b11 = 240 ticks. A trigger sampled in the last lockout cycle is ignored. A trigger sampled one cycle later starts the timer.
- R6: While `out_on` is low, a trigger with `inhibit` high leaves `out_on` low.
- R7: While `out_on` is high, `inhibit` has no effect, and retriggering reloads the duration as in R4.
- R8: Durations count only cycles with `tick` high. With `tick` low, the on time is held. A trigger and a tick in the same cycle reload the duration and do not decrement it.
- R9: Every trigger, in any state and at any `inhibit` level, drives `ind_on` high for IND_TICKS (default 6) tick cycles from the next edge, restarting on each trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one cycle per count |
| trig | input | 1 | Qualified motion pulse |
| inhibit | input | 1 | Blocks activation from the off state |
| tsel | input | 4 | On-time select code |
| lsel | input | 2 | Lockout length select |
| out_on | output | 1 | Timer output, high while on |
| ind_on | output | 1 | Motion indicator one-shot |

## Verification
Single triggers with a continuous tick measure the on time for each quarter-minute code and for the first, a late and the largest minute code. These tell a wrong code mapping apart from an off-by-one in the count. A trigger placed in the last lockout cycle, followed by one in the next cycle, pins each of the four lockout lengths exactly. Three more cases each separate one behaviour. A mid-duration retrigger with a different code shows that the duration reloads and the code is re-sampled. Inhibited triggers from idle, followed by inhibited retriggers while on, separate the two inhibit cases. A stopped tick shows that the block counts ticks and not clock cycles.

// File: rtl/otl_pkg.sv
package otl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ON   = 2'd1,
      ST_LOCK = 2'd2
   } otl_state_e;

   // minute count used by the long on-time codes
   function automatic int unsigned otl_minutes(input logic [3:0] code);
      int unsigned m;
      if (code <= 4'd12)      m = int'(code) - 2;
      else if (code == 4'd13) m = 12;
      else if (code == 4'd14) m = 14;
      else                    m = 15;
      return m;
   endfunction

   // on time in seconds for any code
   function automatic int unsigned otl_seconds(input logic [3:0] code);
      int unsigned s;
      if (code < 4'd4) s = (int'(code) + 1) * 15;
      else             s = otl_minutes(code) * 60;
      return s;
   endfunction
endpackage

// File: rtl/otl_dur_sel.sv
module otl_dur_sel #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned TICK_HZ     = 60,
   parameter bit          USE_FORMULA = 1'b1
) (
   input  logic [3:0]       code,
   output logic [CNT_W-1:0] ticks
);
   import otl_pkg::*;

   generate
      if (USE_FORMULA) begin : g_formula
         always_comb ticks = CNT_W'(otl_seconds(code) * TICK_HZ);
      end else begin : g_table
         int unsigned secs;
         always_comb begin
            unique case (code)
               4'd0:  secs = 15;
               4'd1:  secs = 30;
               4'd2:  secs = 45;
               4'd3:  secs = 60;
               4'd4:  secs = 120;
               4'd5:  secs = 180;
               4'd6:  secs = 240;
               4'd7:  secs = 300;
               4'd8:  secs = 360;
               4'd9:  secs = 420;
               4'd10: secs = 480;
               4'd11: secs = 540;
               4'd12: secs = 600;
               4'd13: secs = 720;
               4'd14: secs = 840;
               default: secs = 900;
            endcase
            ticks = CNT_W'(secs * TICK_HZ);
         end
      end
   endgenerate
endmodule

// File: rtl/otl_lock_sel.sv
module otl_lock_sel #(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned TICK_HZ      = 60,
   parameter int unsigned LOCK_SHORT_S = 1,
   parameter int unsigned LOCK_MID_S   = 4,
   parameter int unsigned LOCK_LONG_S  = 8
) (
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] ticks
);
   localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(LOCK_SHORT_S * TICK_HZ);
   localparam logic [CNT_W-1:0] T_MID   = CNT_W'(LOCK_MID_S * TICK_HZ);
   localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LOCK_LONG_S * TICK_HZ);

   always_comb begin
      unique case (sel)
         2'b00:   ticks = T_SHORT;
         2'b10:   ticks = T_LONG;
         default: ticks = T_MID;   // 01 and the unused 11 both mean middle
      endcase
   end
endmodule

// File: rtl/otl_downcnt.sv
module otl_downcnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] count,
   output logic         is_one
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 q <= '0;
      else if (load)              q <= load_val;
      else if (dec && q != '0)    q <= q - 1'b1;
   end

   assign count  = q;
   assign is_one = (q == W'(1));
endmodule

// File: rtl/otl_oneshot.sv
module otl_oneshot #(
   parameter int unsigned LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic step,
   output logic active
);
   localparam int unsigned W = $clog2(LEN + 1);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 q <= '0;
      else if (fire)              q <= W'(LEN);
      else if (step && q != '0)   q <= q - 1'b1;
   end

   assign active = (q != '0);
endmodule

// File: rtl/otl_timer.sv
module otl_timer #(
   parameter int unsigned TICK_HZ      = 60,
   parameter int unsigned MAX_TICKS    = 54000,
   parameter int unsigned IND_TICKS    = 6,
   parameter int unsigned LOCK_SHORT_S = 1,
   parameter int unsigned LOCK_MID_S   = 4,
   parameter int unsigned LOCK_LONG_S  = 8,
   parameter bit          USE_FORMULA  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       trig,
   input  logic       inhibit,
   input  logic [3:0] tsel,
   input  logic [1:0] lsel,
   output logic       out_on,
   output logic       ind_on
);
   import otl_pkg::*;

   localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

   if (MAX_TICKS < 900 * TICK_HZ) begin : g_bad_max
      $error("MAX_TICKS cannot hold the longest on time");
   end
   if (LOCK_LONG_S * TICK_HZ > MAX_TICKS) begin : g_bad_lock
      $error("lockout length exceeds counter range");
   end
   if (IND_TICKS == 0) begin : g_bad_ind
      $error("IND_TICKS must be nonzero");
   end

   otl_state_e       st_q, st_d;
   logic [CNT_W-1:0] dur_val, lock_val, m_val, m_cnt;
   logic             m_load, m_dec, m_one;
   logic             start, reload, on_done, lock_done;

   otl_dur_sel #(.CNT_W(CNT_W), .TICK_HZ(TICK_HZ), .USE_FORMULA(USE_FORMULA)) u_dur (
      .code (tsel),
      .ticks(dur_val)
   );

   otl_lock_sel #(
      .CNT_W(CNT_W), .TICK_HZ(TICK_HZ),
      .LOCK_SHORT_S(LOCK_SHORT_S), .LOCK_MID_S(LOCK_MID_S), .LOCK_LONG_S(LOCK_LONG_S)
   ) u_lock (
      .sel  (lsel),
      .ticks(lock_val)
   );

   always_comb begin
      start     = (st_q == ST_IDLE) && trig && !inhibit;
      reload    = (st_q == ST_ON) && trig;
      on_done   = (st_q == ST_ON) && !trig && tick && m_one;
      lock_done = (st_q == ST_LOCK) && tick && m_one;
      m_load    = start || reload || on_done;
      m_val     = on_done ? lock_val : dur_val;
      m_dec     = tick && !m_load && (st_q != ST_IDLE);
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start)     st_d = ST_ON;
         ST_ON:   if (on_done)   st_d = ST_LOCK;
         ST_LOCK: if (lock_done) st_d = ST_IDLE;
         default:                st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   otl_downcnt #(.W(CNT_W)) u_main (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (m_load),
      .load_val(m_val),
      .dec     (m_dec),
      .count   (m_cnt),
      .is_one  (m_one)
   );

   otl_oneshot #(.LEN(IND_TICKS)) u_ind (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (trig),
      .step  (tick),
      .active(ind_on)
   );

   assign out_on = (st_q == ST_ON);
endmodule

// File: rtl/otl_timer_chk.sv
module otl_timer_chk #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned MAX_TICKS = 54000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             trig,
   input logic             inhibit,
   input logic             out_on,
   input logic             ind_on,
   input logic [1:0]       state,
   input logic [CNT_W-1:0] cnt
);
   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_on && !ind_on && state == 2'd0)); // R1
   AST_START_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && trig && !inhibit) |=> out_on); // R2
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAX_TICKS)); // R3
   AST_RETRIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_on && trig) |=> out_on); // R4
   AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |=> !out_on); // R5
   AST_FALL_TO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_on) |-> (state == 2'd2)); // R5
   AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_on && inhibit) |=> !out_on); // R6
   AST_INHIBIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (out_on && inhibit && trig) |=> (out_on && state == 2'd1)); // R7
   AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd0 && !tick && !trig) |=> ($stable(cnt) && $stable(state))); // R8
   AST_IND_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> ind_on); // R9
endmodule

bind otl_timer otl_timer_chk #(.CNT_W(CNT_W), .MAX_TICKS(MAX_TICKS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .trig   (trig),
   .inhibit(inhibit),
   .out_on (out_on),
   .ind_on (ind_on),
   .state  (st_q),
   .cnt    (m_cnt)
);

// File: tb/tb_otl_timer.sv
module tb_otl_timer;
   localparam int IND = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       trig = 1'b0;
   logic       inhibit = 1'b0;
   logic [3:0] tsel = 4'd0;
   logic [1:0] lsel = 2'b00;
   logic       out_on, ind_on;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   otl_timer #(.IND_TICKS(IND)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .inhibit(inhibit),
      .tsel(tsel), .lsel(lsel), .out_on(out_on), .ind_on(ind_on)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_dur(input int c);
      int m;
      if (c < 4) return (c + 1) * 900;
      if (c <= 12) m = c - 2;
      else if (c == 13) m = 12;
      else if (c == 14) m = 14;
      else m = 15;
      return m * 3600;
   endfunction

   // drive one trigger cycle; returns at the negedge after the sampling edge
   task automatic pulse(input logic [3:0] code);
      @(negedge clk); tsel = code; trig = 1'b1;
      @(negedge clk); trig = 1'b0;
   endtask

   task automatic count_on(output int n);
      n = 0;
      while (out_on) begin n++; @(negedge clk); end
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      check(out_on == 1'b0, "R1 out_on", int'(out_on), 0);
      check(ind_on == 1'b0, "R1 ind_on", int'(ind_on), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(out_on == 1'b0, "R1 out_on after release", int'(out_on), 0);
   endtask

   task automatic t_durations();
      int codes[7] = '{0, 1, 2, 3, 4, 13, 15};
      foreach (codes[i]) begin
         int n;
         pulse(4'(codes[i]));
         count_on(n);
         check(n == exp_dur(codes[i]), codes[i] < 4 ? "R2 short code on time" : "R3 minute code on time",
               n, exp_dur(codes[i]));
         idle_wait(100);
      end
   endtask

   task automatic t_lockout();
      int lens[4] = '{60, 240, 480, 240};
      for (int s = 0; s < 4; s++) begin
         int n;
         lsel = 2'(s);
         pulse(4'd0);
         count_on(n);
         idle_wait(lens[s] - 1);
         trig = 1'b1;
         @(negedge clk);
         check(out_on == 1'b0, "R5 trigger in last lockout cycle ignored", int'(out_on), 0);
         @(negedge clk); trig = 1'b0;
         check(out_on == 1'b1, "R5 trigger after lockout accepted", int'(out_on), 1);
         count_on(n);
         idle_wait(lens[s] + 5);
      end
      lsel = 2'b00;
   endtask

   task automatic t_retrigger();
      int n;
      pulse(4'd0);
      idle_wait(300);
      check(out_on == 1'b1, "R4 on before retrigger", int'(out_on), 1);
      pulse(4'd1);
      count_on(n);
      check(n == 1800, "R4 reload with new code", n, 1800);
      idle_wait(100);
   endtask

   task automatic t_inhibit();
      int n;
      inhibit = 1'b1;
      pulse(4'd0);
      check(out_on == 1'b0, "R6 inhibited start", int'(out_on), 0);
      idle_wait(20);
      check(out_on == 1'b0, "R6 still off", int'(out_on), 0);
      inhibit = 1'b0;
      pulse(4'd0);
      inhibit = 1'b1;
      idle_wait(200);
      check(out_on == 1'b1, "R7 inhibit while on", int'(out_on), 1);
      pulse(4'd0);
      count_on(n);
      check(n == 900, "R7 retrigger under inhibit", n, 900);
      inhibit = 1'b0;
      idle_wait(100);
   endtask

   task automatic t_tick_hold();
      int n;
      pulse(4'd0);
      tick = 1'b0;
      idle_wait(100);
      check(out_on == 1'b1, "R8 held without tick", int'(out_on), 1);
      tick = 1'b1;
      count_on(n);
      check(n == 900, "R8 counts ticks only", n, 900);
      idle_wait(100);
   endtask

   task automatic t_indicator();
      int n;
      inhibit = 1'b1;
      pulse(4'd2);
      check(out_on == 1'b0, "R9 inhibit keeps output off", int'(out_on), 0);
      n = 0;
      while (ind_on) begin n++; @(negedge clk); end
      check(n == IND, "R9 indicator length under inhibit", n, IND);
      inhibit = 1'b0;
      idle_wait(10);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 195000) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_indicator();
      t_inhibit();
      t_retrigger();
      t_tick_hold();
      t_lockout();
      t_durations();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule